// File: doc/BRIEF.md
# GPIO Pin Controller with Per-Pin Event Detection

This block is a memory-mapped general-purpose pin controller for up to sixteen pins, twelve by default. Every pin has a direction bit and an output latch. Its input passes through a two-stage synchroniser and can always be read back. Each pin also has an event detector. The detector recognises one of five trigger kinds: rising edge, falling edge, both edges, level low or level high. Detected events set a pending bit. Pending bits that are unmasked combine into one interrupt line.

Software reaches the block through a word-wide register port. A single bus access is either a write, applied at the clock edge, or a combinational read. Masks are set and cleared through two separate write-one registers, and pending bits are acknowledged by writing ones. A soft-reset bit holds every configuration register and every pending bit at its default for as long as it is 1. Software sets it and then clears it, and programs the block again afterwards.

Top module: `pin_event_ctrl`

## Requirements
- R1: After reset, the enable, mask, output, direction and trigger registers and the status all read 0, `irq` is low and `pin_oe` is 0.
- R2: A direction bit (word 0x20) of 1 makes the pin an output: `pin_oe` follows the direction register and `pin_out` follows the output register (word 0x18), which reads back as written.
- R3: The input word (0x1C) returns the synchronised pin value two clock edges after the pin changes, whatever the direction. Writes to it have no effect.
- R4: Trigger code 1 (rising) sets the pin's pending bit on a 0-to-1 transition of the synchronised input and not on a 1-to-0 transition.
- R5: Trigger code 0 (falling) sets the pending bit on a 1-to-0 transition and not on a 0-to-1 transition.
- R6: Trigger code 4 (both) sets the pending bit on either transition.
- R7: Trigger codes 2 (level low) and 3 (level high) set the pending bit while the input sits at that level. An acknowledge issued while the level persists leaves the bit set. After the level goes away, an acknowledge clears it.
- R8: A pending bit is set only while the pin's enable bit (word 0x00) is 1.
- R9: Writing ones to word 0x10 masks those pins and writing ones to word 0x14 unmasks them. Zero bits leave the mask unchanged, and either word reads the mask. `irq` is high exactly when some pending bit is set and unmasked. Word 0x08 reads status with masked bits removed.
- R10: The status word (0x04) holds an edge-triggered pending bit until a 1 is written to that bit of the acknowledge word (0x0C).
- R11: Bit 0 of word 0x3C is a soft reset. While it reads 1, every other register and every pending bit is held at its reset value. After software writes it back to 0, the block stays in its defaults.
- R12: Pin p below 8 takes its trigger from word 0x24 bits [4p+2:4p]. Pin p of 8 and above takes it from word 0x28 bits [4(p-8)+2:4(p-8)]. The top bit of each 4-bit field, and every bit at or above the pin count in the per-pin words, reads 0 and ignores writes.
- R13: When an acknowledge and a new event on the same pin fall in the same clock edge, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_cs | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write at the clock edge, 0 = read |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Output latch value |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
An acknowledge write and a fresh detector event can land on the same pin at the same clock edge, and the two act on the same pending bit in opposite directions. The bench raises a pending bit on a pin set to both edges. It then flips that pin and times the acknowledge write to take effect at exactly the edge where the synchroniser exposes the transition. The status read that follows must show the bit still set. A level-high pin acknowledged while still high is judged the same way.

// File: rtl/pec_pkg.sv
package pec_pkg;

  typedef enum logic [2:0] {
    TRIG_FALL = 3'd0,
    TRIG_RISE = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_HIGH = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  localparam logic [3:0] RG_ENABLE = 4'h0;
  localparam logic [3:0] RG_STATUS = 4'h1;
  localparam logic [3:0] RG_VIEW   = 4'h2;
  localparam logic [3:0] RG_ACK    = 4'h3;
  localparam logic [3:0] RG_MSET   = 4'h4;
  localparam logic [3:0] RG_MCLR   = 4'h5;
  localparam logic [3:0] RG_OUT    = 4'h6;
  localparam logic [3:0] RG_IN     = 4'h7;
  localparam logic [3:0] RG_DIR    = 4'h8;
  localparam logic [3:0] RG_TRIG0  = 4'h9;
  localparam logic [3:0] RG_TRIG1  = 4'hA;
  localparam logic [3:0] RG_SRST   = 4'hF;

  localparam int FIELD_W       = 4;
  localparam int PINS_PER_WORD = 8;

endpackage

// File: rtl/pec_sync.sv
module pec_sync #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/pec_detect.sv
module pec_detect
  import pec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blk_rst,
  input  logic       lvl_i,
  input  logic       en_i,
  input  logic       ack_i,
  input  logic [2:0] trig_i,
  output logic       pend_o
);

  logic prev_q;
  logic pend_q;
  logic pend_d;
  logic hit;
  logic rise;
  logic fall;

  always_comb begin
    rise = lvl_i & ~prev_q;
    fall = ~lvl_i & prev_q;
    case (trig_i)
      TRIG_FALL: hit = fall;
      TRIG_RISE: hit = rise;
      TRIG_LOW:  hit = ~lvl_i;
      TRIG_HIGH: hit = lvl_i;
      TRIG_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    if (blk_rst) pend_d = 1'b0;
    else         pend_d = (pend_q & ~ack_i) | (hit & en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R8: a disabled pin never gains a pending bit
  a_r8_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !pend_q) |=> !pend_q);

  // R10: pending stays until acknowledged or block reset
  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_rst && pend_q && !ack_i) |=> pend_q);

  // R7: level high with enable present is pending next cycle, even if acked
  a_r7_level_high_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_rst && en_i && trig_i == TRIG_HIGH && lvl_i) |=> pend_q);

endmodule

// File: rtl/pec_regs.sv
module pec_regs
  import pec_pkg::*;
#(
  parameter int NPINS = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_i,
  input  logic                  we_i,
  input  logic [5:0]            addr_i,
  input  logic [31:0]           wdata_i,
  input  logic [NPINS-1:0]      pend_i,
  input  logic [NPINS-1:0]      lvl_i,
  output logic [NPINS-1:0]      en_o,
  output logic [NPINS-1:0]      mask_o,
  output logic [NPINS-1:0]      dir_o,
  output logic [NPINS-1:0]      out_o,
  output logic [NPINS-1:0][2:0] trig_o,
  output logic [NPINS-1:0]      ack_o,
  output logic                  blk_rst_o,
  output logic [31:0]           rdata_o
);

  localparam int TW = 3;

  logic [3:0]       idx;
  logic             wr;
  logic [NPINS-1:0] wpins;

  logic [NPINS-1:0] en_q, en_d, mask_q, mask_d, dir_q, dir_d, out_q, out_d;
  logic             en_ld, mask_ld, dir_ld, out_ld, trig_ld;
  logic [TW-1:0]    trig_q [NPINS];
  logic [TW-1:0]    trig_d [NPINS];
  logic             srst_q, srst_d, srst_ld;

  wire  [TW-1:0]    trig_src [NPINS];
  wire  [NPINS-1:0] trig_hit;
  wire  [31:0]      t0_part [NPINS];
  wire  [31:0]      t1_part [NPINS];
  logic [31:0]      t0_rd, t1_rd;

  logic unused_bus;
  assign unused_bus = ^{wdata_i, addr_i[1:0]};

  assign idx   = addr_i[5:2];
  assign wr    = cs_i & we_i;
  assign wpins = wdata_i[NPINS-1:0];

  for (genvar P = 0; P < NPINS; P++) begin : g_field
    if (P < PINS_PER_WORD) begin : g_lo
      assign trig_src[P] = wdata_i[FIELD_W*P +: TW];
      assign trig_hit[P] = wr && (idx == RG_TRIG0);
      assign t0_part[P]  = 32'(trig_q[P]) << (FIELD_W*P);
      assign t1_part[P]  = '0;
    end else begin : g_hi
      assign trig_src[P] = wdata_i[FIELD_W*(P-PINS_PER_WORD) +: TW];
      assign trig_hit[P] = wr && (idx == RG_TRIG1);
      assign t0_part[P]  = '0;
      assign t1_part[P]  = 32'(trig_q[P]) << (FIELD_W*(P-PINS_PER_WORD));
    end
  end

  // next state and load enables
  always_comb begin
    en_ld   = srst_q | (wr && idx == RG_ENABLE);
    mask_ld = srst_q | (wr && (idx == RG_MSET || idx == RG_MCLR));
    dir_ld  = srst_q | (wr && idx == RG_DIR);
    out_ld  = srst_q | (wr && idx == RG_OUT);
    trig_ld = srst_q | (|trig_hit);
    srst_ld = wr && idx == RG_SRST;

    en_d   = srst_q ? '0 : wpins;
    dir_d  = srst_q ? '0 : wpins;
    out_d  = srst_q ? '0 : wpins;
    mask_d = mask_q;
    if (srst_q)              mask_d = '0;
    else if (idx == RG_MSET) mask_d = mask_q | wpins;
    else                     mask_d = mask_q & ~wpins;
    for (int p = 0; p < NPINS; p++) begin
      if (srst_q)           trig_d[p] = '0;
      else if (trig_hit[p]) trig_d[p] = trig_src[p];
      else                  trig_d[p] = trig_q[p];
    end
    srst_d = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      srst_q <= 1'b0;
      for (int p = 0; p < NPINS; p++) trig_q[p] <= '0;
    end else begin
      if (en_ld)   en_q   <= en_d;
      if (mask_ld) mask_q <= mask_d;
      if (dir_ld)  dir_q  <= dir_d;
      if (out_ld)  out_q  <= out_d;
      if (srst_ld) srst_q <= srst_d;
      if (trig_ld) for (int p = 0; p < NPINS; p++) trig_q[p] <= trig_d[p];
    end
  end

  // read mux
  always_comb begin
    t0_rd = '0;
    t1_rd = '0;
    for (int p = 0; p < NPINS; p++) begin
      t0_rd = t0_rd | t0_part[p];
      t1_rd = t1_rd | t1_part[p];
    end
    case (idx)
      RG_ENABLE: rdata_o = 32'(en_q);
      RG_STATUS: rdata_o = 32'(pend_i);
      RG_VIEW:   rdata_o = 32'(pend_i & ~mask_q);
      RG_MSET:   rdata_o = 32'(mask_q);
      RG_MCLR:   rdata_o = 32'(mask_q);
      RG_OUT:    rdata_o = 32'(out_q);
      RG_IN:     rdata_o = 32'(lvl_i);
      RG_DIR:    rdata_o = 32'(dir_q);
      RG_TRIG0:  rdata_o = t0_rd;
      RG_TRIG1:  rdata_o = t1_rd;
      RG_SRST:   rdata_o = {31'b0, srst_q};
      default:   rdata_o = '0;
    endcase
  end

  always_comb begin
    for (int p = 0; p < NPINS; p++) trig_o[p] = trig_q[p];
  end

  assign en_o      = en_q;
  assign mask_o    = mask_q;
  assign dir_o     = dir_q;
  assign out_o     = out_q;
  assign blk_rst_o = srst_q;
  assign ack_o     = (wr && idx == RG_ACK && !srst_q) ? wpins : '0;

  // R9: ones written to mask-set are masked on the next cycle
  a_r9_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == RG_MSET && !srst_q) |=>
      ((mask_q & $past(wpins)) == $past(wpins)));

  // R11: soft reset holds configuration at defaults
  a_r11_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (en_q == '0 && mask_q == '0 && dir_q == '0 && out_q == '0));

  // R12: direction word never shows bits above the pin count
  a_r12_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_i && !we_i && idx == RG_DIR) |-> (rdata_o[31:NPINS] == '0));

endmodule

// File: rtl/pin_event_ctrl.sv
module pin_event_ctrl
  import pec_pkg::*;
#(
  parameter int NPINS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_cs,
  input  logic             bus_we,
  input  logic [5:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);

  logic             rst_meta_q, rst_sync_n;
  logic [NPINS-1:0] lvl, pend, en, mask, dir, outv, ack;
  logic [NPINS-1:0][2:0] trig;
  logic             blk_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  pec_sync #(.W(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (pin_in),
    .sync_o  (lvl)
  );

  pec_regs #(.NPINS(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cs_i      (bus_cs),
    .we_i      (bus_we),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .pend_i    (pend),
    .lvl_i     (lvl),
    .en_o      (en),
    .mask_o    (mask),
    .dir_o     (dir),
    .out_o     (outv),
    .trig_o    (trig),
    .ack_o     (ack),
    .blk_rst_o (blk_rst),
    .rdata_o   (bus_rdata)
  );

  for (genvar P = 0; P < NPINS; P++) begin : g_det
    pec_detect u_det (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .blk_rst (blk_rst),
      .lvl_i   (lvl[P]),
      .en_i    (en[P]),
      .ack_i   (ack[P]),
      .trig_i  (trig[P]),
      .pend_o  (pend[P])
    );
  end

  assign pin_out = outv;
  assign pin_oe  = dir;
  assign irq     = |(pend & ~mask);

  // R11: soft reset clears every pending bit by the next cycle
  a_r11_pend_cleared: assert property (@(posedge clk) disable iff (!rst_sync_n)
    blk_rst |=> (pend == '0));

endmodule

// File: tb/pin_event_ctrl_test.sv
module pin_event_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int N = 12;
  localparam int WATCHDOG = 20000;

  localparam logic [5:0] A_EN = 6'h00, A_ST = 6'h04, A_VIEW = 6'h08, A_ACK = 6'h0C,
                         A_MSET = 6'h10, A_MCLR = 6'h14, A_OUT = 6'h18, A_IN = 6'h1C,
                         A_DIR = 6'h20, A_TR0 = 6'h24, A_TR1 = 6'h28, A_SRST = 6'h3C;

  localparam int K_RD = 0, K_IRQ = 1, K_OE = 2, K_OUT = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_cs = 1'b0, bus_we = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_oe;
  logic          irq;
  logic          mon_go = 1'b0;

  item_t sb_q[$];
  int    compared = 0;
  int    mismatched = 0;
  int    cycles = 0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_event_ctrl #(.NPINS(N)) uut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // monitor: pops expectations and compares against the design
  always @(negedge clk) begin
    if (mon_go && sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        K_RD:    act = bus_rdata;
        K_IRQ:   act = {31'b0, irq};
        K_OE:    act = 32'(pin_oe);
        default: act = 32'(pin_out);
      endcase
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > WATCHDOG) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, string tag);
    item_t it;
    it.kind = K_RD; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a; mon_go = 1'b1;
    @(posedge clk); #1;
    bus_cs = 1'b0; mon_go = 1'b0;
  endtask

  task automatic port(int k, logic [31:0] e, string tag);
    item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    mon_go = 1'b1;
    @(posedge clk); #1;
    mon_go = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(A_ST, 32'h0, "R1 status");
    rd(A_EN, 32'h0, "R1 enable");
    rd(A_MSET, 32'h0, "R1 mask");
    rd(A_TR0, 32'h0, "R1 trig0");
    port(K_IRQ, 32'h0, "R1 irq");
    port(K_OE, 32'h0, "R1 pin_oe");

    // R12 upper bits, R2 direction and output
    wr(A_DIR, 32'hFFFF_FFFF);
    rd(A_DIR, 32'h0000_0FFF, "R12 dir upper bits");
    wr(A_DIR, 32'h0000_000F);
    wr(A_OUT, 32'h0000_00A5);
    port(K_OE, 32'h0000_000F, "R2 pin_oe");
    port(K_OUT, 32'h0000_00A5, "R2 pin_out");
    rd(A_OUT, 32'h0000_00A5, "R2 output readback");

    // R3 input sampling, writes ignored
    pin_in = 12'h5A3;
    idle(3);
    rd(A_IN, 32'h0000_05A3, "R3 input");
    wr(A_IN, 32'h0);
    rd(A_IN, 32'h0000_05A3, "R3 input write ignored");
    pin_in = '0;
    idle(3);

    // trigger setup: pin0 rise, pin1 fall, pin2 both, pin3 high, pin4 rise
    wr(A_TR0, 32'h0001_3409);
    rd(A_TR0, 32'h0001_3401, "R12 field top bit");
    wr(A_EN, 32'h0000_000F);
    idle(3);
    rd(A_ST, 32'h0, "R1 quiet before events");

    // R4 rising
    pin_in[0] = 1'b1; idle(3);
    rd(A_ST, 32'h001, "R4 rise sets");
    wr(A_ACK, 32'h001);
    pin_in[0] = 1'b0; idle(3);
    rd(A_ST, 32'h000, "R4 fall ignored");

    // R5 falling
    pin_in[1] = 1'b1; idle(3);
    rd(A_ST, 32'h000, "R5 rise ignored");
    pin_in[1] = 1'b0; idle(3);
    rd(A_ST, 32'h002, "R5 fall sets");
    wr(A_ACK, 32'h002);
    rd(A_ST, 32'h000, "R10 ack clears pin1");

    // R6 both edges
    pin_in[2] = 1'b1; idle(3);
    rd(A_ST, 32'h004, "R6 rise sets");
    wr(A_ACK, 32'h004);
    rd(A_ST, 32'h000, "R6 ack");
    pin_in[2] = 1'b0; idle(3);
    rd(A_ST, 32'h004, "R6 fall sets");
    wr(A_ACK, 32'h004);

    // R7 level high
    pin_in[3] = 1'b1; idle(3);
    rd(A_ST, 32'h008, "R7 level high sets");
    wr(A_ACK, 32'h008);
    rd(A_ST, 32'h008, "R7 re-set while high");
    pin_in[3] = 1'b0; idle(3);
    wr(A_ACK, 32'h008);
    rd(A_ST, 32'h000, "R7 cleared after level gone");

    // R8 enable gating on pin4
    pin_in[4] = 1'b1; idle(3);
    rd(A_ST, 32'h000, "R8 disabled pin");
    pin_in[4] = 1'b0; idle(3);

    // R7 level low on pin9 via second trigger word
    wr(A_TR1, 32'h0000_0020);
    rd(A_TR1, 32'h0000_0020, "R12 trig1 placement");
    wr(A_EN, 32'h0000_020F);
    idle(1);
    rd(A_ST, 32'h200, "R7 level low sets");
    pin_in[9] = 1'b1; idle(3);
    wr(A_ACK, 32'h200);
    rd(A_ST, 32'h000, "R7 level low cleared");

    // R9 masking and combined line
    pin_in[0] = 1'b1; idle(3);
    port(K_IRQ, 32'h1, "R9 irq unmasked");
    rd(A_VIEW, 32'h001, "R9 view unmasked");
    wr(A_MSET, 32'h001);
    rd(A_MSET, 32'h001, "R9 mask set");
    port(K_IRQ, 32'h0, "R9 irq masked");
    rd(A_VIEW, 32'h000, "R9 view masked");
    rd(A_ST, 32'h001, "R9 status under mask");
    wr(A_MSET, 32'h004);
    rd(A_MCLR, 32'h005, "R9 zero bits keep mask");
    wr(A_MCLR, 32'h001);
    rd(A_MSET, 32'h004, "R9 mask clear");
    port(K_IRQ, 32'h1, "R9 irq after unmask");
    wr(A_MCLR, 32'h004);
    idle(5);
    rd(A_ST, 32'h001, "R10 edge pending held");
    wr(A_ACK, 32'h001);
    port(K_IRQ, 32'h0, "R10 irq after ack");

    // R13 ack coinciding with new event on pin2 (both edges)
    pin_in[2] = 1'b1; idle(3);
    rd(A_ST, 32'h004, "R13 setup pending");
    pin_in[2] = 1'b0;
    idle(2);
    wr(A_ACK, 32'h004);
    rd(A_ST, 32'h004, "R13 event wins over ack");
    wr(A_ACK, 32'h004);
    rd(A_ST, 32'h000, "R13 plain ack clears");

    // R11 soft reset
    wr(A_MSET, 32'h002);
    wr(A_SRST, 32'h1);
    rd(A_SRST, 32'h1, "R11 reset bit reads");
    wr(A_SRST, 32'h0);
    rd(A_EN, 32'h0, "R11 enable default");
    rd(A_DIR, 32'h0, "R11 dir default");
    rd(A_TR0, 32'h0, "R11 trig default");
    rd(A_MSET, 32'h0, "R11 mask default");
    rd(A_ST, 32'h0, "R11 status default");
    port(K_OE, 32'h0, "R11 pin_oe default");
    port(K_IRQ, 32'h0, "R11 irq default");

    idle(2);
    if (sb_q.size() != 0) begin
      compared++;
      mismatched++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb_q.size());
    end
    done = 1'b1;
    summary();
  end

endmodule